// File: doc/BRIEF.md
# Ping-Pong Subfield Frame Memory Controller

This block drives the address and strobe pins of two external frame memory banks that take turns. During a frame, one bank takes the packed colour words coming from the input side. The other bank is read out at the same time, one colour region after another, to feed the sequential-colour display. Each bank is divided into three equal regions, one each for red, green and blue. A write lands at a shared pixel-group counter plus the base of its colour region. The read side steps its own counter with each display request. A subfield sync sends it back to the start of the next colour region.

The two banks change roles on the rising edge of the input frame sync and at no other time. A frame that is still being written is therefore never shown. Strobes are active low. The design computes them combinationally from the registered state and the current request inputs, so the memories see the address and the strobe in the same cycle as the request.

Top module: `subfield_bank_ctrl`

## Requirements
- R1: After reset the write side is bank 0 (`wr_bank_sel` = 0), both counters are zero, the read region is red, and every strobe is high while no request is present.
- R2: The write-bank address is the colour base plus the write counter. Colour code 0 (red) has base 0, code 1 (green) has base REGION_WORDS, and code 2 (blue) has base 2*REGION_WORDS. The write strobe of the write bank is low in a cycle with `wr_valid` high and a colour code below 3.
- R3: The write counter steps by one after each accepted blue (code 2) write and holds after red or green writes. Colour code 3 is ignored: it produces no write strobe and leaves the counter unchanged.
- R4: When the write counter reaches REGION_WORDS it stays there, and no further write strobe is issued until the next frame start.
- R5: The read bank is always the bank not being written. Its address is the current read region base plus the read counter. Its read strobe is low in a cycle with `rd_req` high.
- R6: The read counter steps by one per accepted read request and holds at REGION_WORDS-1.
- R7: `rd_subsync` forces the read strobe high in its cycle, clears the read counter and moves the read region red, green, blue, then back to red.
- R8: A rising edge on `in_vsync` forces all strobes high in its cycle. It swaps the banks from the next cycle, clears both counters and returns the read region to red. If `in_vsync` is held high, the banks swap only once.
- R9: A bank never has its write strobe and its read strobe low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vsync | input | 1 | Input frame sync, rising edge starts a frame |
| wr_valid | input | 1 | A packed word is ready to be written |
| wr_color | input | 2 | Colour of the word: 0 red, 1 green, 2 blue, 3 none |
| rd_req | input | 1 | Display side requests the next word |
| rd_subsync | input | 1 | Start of the next colour subfield on the read side |
| bank0_addr | output | ADDR_W | Address to bank 0 |
| bank1_addr | output | ADDR_W | Address to bank 1 |
| bank0_w_n | output | 1 | Bank 0 write strobe, active low |
| bank1_w_n | output | 1 | Bank 1 write strobe, active low |
| bank0_g_n | output | 1 | Bank 0 output-read strobe, active low |
| bank1_g_n | output | 1 | Bank 1 output-read strobe, active low |
| wr_bank_sel | output | 1 | Bank currently written (0 or 1) |

## Verification
A write and a read fall in the same cycle in normal use, one on each bank. The bench therefore drives `wr_valid` and `rd_req` together in many table rows. It checks that the write bank carries the colour-region write address with W low, that the other bank carries the read address with G low, and that the remaining strobes stay high. A frame-start edge is also provoked together with both requests. In that cycle all strobes must stay high, and the swapped roles must show in the next row.

// File: rtl/subfield_bank_ctrl.sv
module subfield_bank_ctrl #(
  parameter int ADDR_W       = 21,
  parameter int REGION_WORDS = 327680
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vsync,
  input  logic              wr_valid,
  input  logic [1:0]        wr_color,
  input  logic              rd_req,
  input  logic              rd_subsync,
  output logic [ADDR_W-1:0] bank0_addr,
  output logic [ADDR_W-1:0] bank1_addr,
  output logic              bank0_w_n,
  output logic              bank1_w_n,
  output logic              bank0_g_n,
  output logic              bank1_g_n,
  output logic              wr_bank_sel
);

  localparam int CNT_W = $clog2(REGION_WORDS + 1);
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(REGION_WORDS);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(REGION_WORDS - 1);
  localparam logic [ADDR_W-1:0] BASE_G   = ADDR_W'(REGION_WORDS);
  localparam logic [ADDR_W-1:0] BASE_B   = ADDR_W'(2 * REGION_WORDS);

  logic             vs_q, wr_bank;
  logic [CNT_W-1:0] wcnt, rcnt;
  logic [1:0]       rcol;
  logic             frame_start, wr_full, wr_go, rd_go;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  function automatic logic [ADDR_W-1:0] region_base(input logic [1:0] c);
    case (c)
      2'd1:    return BASE_G;
      2'd2:    return BASE_B;
      default: return '0;
    endcase
  endfunction

  assign frame_start = rst_n && in_vsync && !vs_q;
  assign wr_full     = (wcnt == CNT_FULL);
  assign wr_go       = rst_n && wr_valid && (wr_color != 2'd3) && !wr_full && !frame_start;
  assign rd_go       = rst_n && rd_req && !rd_subsync && !frame_start;

  assign wr_addr = region_base(wr_color) + ADDR_W'(wcnt);
  assign rd_addr = region_base(rcol) + ADDR_W'(rcnt);

  assign bank0_addr  = wr_bank ? rd_addr : wr_addr;
  assign bank1_addr  = wr_bank ? wr_addr : rd_addr;
  assign bank0_w_n   = !(wr_go && !wr_bank);
  assign bank1_w_n   = !(wr_go && wr_bank);
  assign bank0_g_n   = !(rd_go && wr_bank);
  assign bank1_g_n   = !(rd_go && !wr_bank);
  assign wr_bank_sel = wr_bank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_q    <= 1'b0;
      wr_bank <= 1'b0;
      wcnt    <= '0;
      rcnt    <= '0;
      rcol    <= 2'd0;
    end else begin
      vs_q <= in_vsync;
      if (frame_start) begin
        wr_bank <= !wr_bank;
        wcnt    <= '0;
        rcnt    <= '0;
        rcol    <= 2'd0;
      end else begin
        if (wr_go && wr_color == 2'd2)
          wcnt <= wcnt + 1'b1;
        if (rd_subsync) begin
          rcnt <= '0;
          rcol <= (rcol == 2'd2) ? 2'd0 : rcol + 2'd1;
        end else if (rd_go && rcnt != CNT_LAST) begin
          rcnt <= rcnt + 1'b1;
        end
      end
    end
  end

  a_r9_bank_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !((!bank0_w_n && !bank0_g_n) || (!bank1_w_n && !bank1_g_n)));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= CNT_FULL);

  a_r6_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= CNT_LAST);

  a_r3_skip_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_color == 2'd3 && !frame_start) |=> $stable(wcnt));

  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_subsync && !frame_start) |=> (rcnt == '0));

  a_r8_swap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (wr_bank != $past(wr_bank)));

  a_r8_quiet_edge: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (bank0_w_n && bank1_w_n && bank0_g_n && bank1_g_n));

endmodule

// File: tb/subfield_bank_ctrl_bench.sv
module subfield_bank_ctrl_bench;
  localparam int AW = 21;
  localparam int RW = 4;
  localparam int N  = 23;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_vsync = 1'b0, wr_valid = 1'b0, rd_req = 1'b0, rd_subsync = 1'b0;
  logic [1:0] wr_color = 2'd0;
  logic [AW-1:0] bank0_addr, bank1_addr;
  logic bank0_w_n, bank1_w_n, bank0_g_n, bank1_g_n, wr_bank_sel;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = !clk;

  subfield_bank_ctrl #(.ADDR_W(AW), .REGION_WORDS(RW)) u_subfield_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .in_vsync(in_vsync), .wr_valid(wr_valid),
    .wr_color(wr_color), .rd_req(rd_req), .rd_subsync(rd_subsync),
    .bank0_addr(bank0_addr), .bank1_addr(bank1_addr),
    .bank0_w_n(bank0_w_n), .bank1_w_n(bank1_w_n),
    .bank0_g_n(bank0_g_n), .bank1_g_n(bank1_g_n), .wr_bank_sel(wr_bank_sel));

  // {req, vs, wv, col, rq, rs, wbank, waddr, raddr, w_n, g_n}
  localparam logic [28:0] VEC [N] = '{
    {4'd2, 1'b0,1'b1,2'd0,1'b0,1'b0, 1'b0, 8'd0,  8'd0,  1'b0,1'b1},
    {4'd5, 1'b0,1'b1,2'd1,1'b1,1'b0, 1'b0, 8'd4,  8'd0,  1'b0,1'b0},
    {4'd2, 1'b0,1'b1,2'd2,1'b1,1'b0, 1'b0, 8'd8,  8'd1,  1'b0,1'b0},
    {4'd3, 1'b0,1'b1,2'd0,1'b0,1'b0, 1'b0, 8'd1,  8'd2,  1'b0,1'b1},
    {4'd3, 1'b0,1'b1,2'd3,1'b0,1'b0, 1'b0, 8'd1,  8'd2,  1'b1,1'b1},
    {4'd7, 1'b0,1'b1,2'd2,1'b0,1'b1, 1'b0, 8'd9,  8'd2,  1'b0,1'b1},
    {4'd7, 1'b0,1'b0,2'd1,1'b1,1'b0, 1'b0, 8'd6,  8'd4,  1'b1,1'b0},
    {4'd7, 1'b0,1'b0,2'd0,1'b1,1'b1, 1'b0, 8'd2,  8'd5,  1'b1,1'b1},
    {4'd5, 1'b0,1'b0,2'd0,1'b1,1'b0, 1'b0, 8'd2,  8'd8,  1'b1,1'b0},
    {4'd6, 1'b0,1'b0,2'd0,1'b1,1'b0, 1'b0, 8'd2,  8'd9,  1'b1,1'b0},
    {4'd6, 1'b0,1'b0,2'd0,1'b1,1'b0, 1'b0, 8'd2,  8'd10, 1'b1,1'b0},
    {4'd6, 1'b0,1'b0,2'd0,1'b1,1'b0, 1'b0, 8'd2,  8'd11, 1'b1,1'b0},
    {4'd6, 1'b0,1'b0,2'd0,1'b1,1'b0, 1'b0, 8'd2,  8'd11, 1'b1,1'b0},
    {4'd7, 1'b0,1'b0,2'd0,1'b0,1'b1, 1'b0, 8'd2,  8'd11, 1'b1,1'b1},
    {4'd7, 1'b0,1'b0,2'd0,1'b1,1'b0, 1'b0, 8'd2,  8'd0,  1'b1,1'b0},
    {4'd4, 1'b0,1'b1,2'd2,1'b0,1'b0, 1'b0, 8'd10, 8'd1,  1'b0,1'b1},
    {4'd4, 1'b0,1'b1,2'd2,1'b0,1'b0, 1'b0, 8'd11, 8'd1,  1'b0,1'b1},
    {4'd4, 1'b0,1'b1,2'd0,1'b0,1'b0, 1'b0, 8'd4,  8'd1,  1'b1,1'b1},
    {4'd8, 1'b1,1'b1,2'd0,1'b1,1'b0, 1'b0, 8'd4,  8'd1,  1'b1,1'b1},
    {4'd8, 1'b1,1'b1,2'd1,1'b1,1'b0, 1'b1, 8'd4,  8'd0,  1'b0,1'b0},
    {4'd8, 1'b0,1'b0,2'd0,1'b0,1'b0, 1'b1, 8'd0,  8'd1,  1'b1,1'b1},
    {4'd8, 1'b1,1'b0,2'd0,1'b0,1'b0, 1'b1, 8'd0,  8'd1,  1'b1,1'b1},
    {4'd9, 1'b0,1'b1,2'd1,1'b1,1'b0, 1'b0, 8'd4,  8'd0,  1'b0,1'b0}
  };

  function automatic string req_name(input int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";
      4: return "R4";  5: return "R5";  6: return "R6";
      7: return "R7";  8: return "R8";  default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic vs, input logic wv, input logic [1:0] col,
                       input logic rq, input logic rs);
    @(negedge clk);
    in_vsync = vs; wr_valid = wv; wr_color = col; rd_req = rq; rd_subsync = rs;
    #1;
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs held in reset
    chk(wr_bank_sel == 1'b0, "R1", "bank in reset", wr_bank_sel, 0);
    chk({bank0_w_n, bank1_w_n, bank0_g_n, bank1_g_n} == 4'hF, "R1", "strobes in reset",
        {bank0_w_n, bank1_w_n, bank0_g_n, bank1_g_n}, 15);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(bank0_addr == 0 && bank1_addr == 0, "R1", "addresses after reset", bank0_addr, 0);

    for (int i = 0; i < N; i++) begin
      logic [28:0] v;
      logic wb;
      int wa, ra;
      logic wn, gn, ow, og;
      string rq;
      v = VEC[i];
      rq = req_name(int'(v[28:25]));
      drive(v[24], v[23], v[22:21], v[20], v[19]);
      wb = wr_bank_sel;
      wa = wb ? int'(bank1_addr) : int'(bank0_addr);
      ra = wb ? int'(bank0_addr) : int'(bank1_addr);
      wn = wb ? bank1_w_n : bank0_w_n;
      gn = wb ? bank0_g_n : bank1_g_n;
      ow = wb ? bank0_w_n : bank1_w_n;
      og = wb ? bank1_g_n : bank0_g_n;
      chk(wb == v[18], rq, $sformatf("row %0d bank", i), wb, v[18]);
      chk(wa == int'(v[17:10]), rq, $sformatf("row %0d write addr", i), wa, v[17:10]);
      chk(ra == int'(v[9:2]), rq, $sformatf("row %0d read addr", i), ra, v[9:2]);
      chk(wn == v[1], rq, $sformatf("row %0d W", i), wn, v[1]);
      chk(gn == v[0], rq, $sformatf("row %0d G", i), gn, v[0]);
      // R9: the other strobe of each bank stays high
      chk(ow && og, "R9", $sformatf("row %0d cross strobes", i), {ow, og}, 3);
    end

    // R8 then R1: swap, then reset mid-run returns to bank 0
    drive(1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
    chk(wr_bank_sel == 1'b1, "R8", "swap before reset", wr_bank_sel, 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(wr_bank_sel == 1'b0, "R1", "bank after mid reset", wr_bank_sel, 0);
    drive(1'b0, 1'b1, 2'd2, 1'b0, 1'b0);
    chk(bank0_addr == 8 && !bank0_w_n, "R1", "counter cleared by reset", bank0_addr, 8);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule